// File: doc/BRIEF.md
# Pad Pull Resistor Controller

This block decides, for every pad in a group, whether the weak pull-up, the weak pull-down or neither is switched on. It offers two programming styles side by side. In the latched style a single shared 2-bit pull code is written once, and each pad takes that code only while its own strobe bit is high; after the strobe drops the pad keeps what it took. The strobe must follow a hold time after the code is written, and a built-in sequencer can run the whole write–wait–strobe–wait–release order for one pad at a time, so that software does not have to time it.

In the direct style every pad owns a 2-bit field in a packed word array that can be written and read back. A mode input picks which of the two styles drives the pad enables. Writes use a one-cycle word write port; reads are combinational.

Top module: `pad_pull_ctrl`

## Requirements
- R1: After reset every pad enable is low, `seq_busy` is low and every read returns 0.
- R2: The shared code sits in the low 2 bits of byte address 0x94. Latched code 1 turns on the pull-down, code 2 turns on the pull-up, and codes 0 and 3 turn both off.
- R3: Strobe words sit at 0x98 + 4*(p/32), pad p at bit p mod 32. A pad takes the shared code on each clock edge where its strobe bit is high and keeps it once the bit is cleared; pads whose bit is low keep their value.
- R4: Writing the shared code while no strobe bit is high leaves every pad enable unchanged.
- R5: Direct fields sit at 0xE4 + 4*(p/16), pad p at bits 2*(p mod 16)+1 and 2*(p mod 16). Field value 1 means pull-up, 2 means pull-down, 0 and 3 mean none. A field reads back as written; bits for pads that do not exist read as 0.
- R6: With `dir_mode` high the direct fields drive the pad enables; with it low the latched codes do.
- R7: The shared code and the strobe words are write-only: reads of 0x94 and of the strobe words return 0.
- R8: A `seq_start` pulse while idle writes `seq_code` into the shared code and raises `seq_busy` for exactly 2*WAIT_CYCLES cycles. The target pad's strobe is high only in the second WAIT_CYCLES cycles, so the pad is unchanged during the first half and holds `seq_code` once `seq_busy` falls.
- R9: A `seq_start` pulse while `seq_busy` is high is ignored: the running sequence neither lengthens nor changes target, and the pad named by the ignored request keeps its value.
- R10: A pad never has its pull-up and pull-down enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Word write strobe |
| bus_waddr | input | 8 | Write byte address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 8 | Read byte address |
| bus_rdata | output | 32 | Read data (combinational) |
| dir_mode | input | 1 | 1: direct fields drive pads, 0: latched codes drive pads |
| seq_start | input | 1 | One-cycle request to the sequencer |
| seq_pin | input | 6 | Target pad of the request |
| seq_code | input | 2 | Shared code for the request |
| seq_busy | output | 1 | Sequencer running |
| pad_pull_up | output | 40 | Per-pad pull-up enable |
| pad_pull_dn | output | 40 | Per-pad pull-down enable |

## Verification
The assertions assume that software does not write the shared code in the same cycle a sequencer request is accepted, and that strobe bits written by software are low while the sequencer holds a pad strobe, since either would let two writers meet on one register. The stimulus keeps all bus writes apart from sequencer activity, only issues a start while idle except for the deliberate ignored request, and uses pad numbers below the pad count.

// File: rtl/pad_pull_pkg.sv
package pad_pull_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_HOLD  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic up;
    logic dn;
  } pull_en_t;

  localparam logic [7:0] ADDR_CODE = 8'h94;
  localparam logic [7:0] ADDR_STB0 = 8'h98;
  localparam logic [7:0] ADDR_DIR0 = 8'hE4;

  // latched style: 1 = down, 2 = up, 0/3 = off
  function automatic pull_en_t dec_latched(input logic [1:0] c);
    pull_en_t r;
    r.up = (c == 2'd2);
    r.dn = (c == 2'd1);
    return r;
  endfunction

  // direct style: 1 = up, 2 = down, 0/3 = none
  function automatic pull_en_t dec_direct(input logic [1:0] c);
    pull_en_t r;
    r.up = (c == 2'd1);
    r.dn = (c == 2'd2);
    return r;
  endfunction

endpackage

// File: rtl/pull_seq.sv
module pull_seq
  import pad_pull_pkg::*;
#(
  parameter int NUM_PINS    = 40,
  parameter int WAIT_CYCLES = 150,
  localparam int PIN_W      = $clog2(NUM_PINS),
  localparam int CNT_W      = $clog2(WAIT_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PIN_W-1:0]    pin,
  input  logic [1:0]          code,
  output logic                busy,
  output logic                code_we,
  output logic [1:0]          code_val,
  output logic [NUM_PINS-1:0] stb
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PIN_W-1:0] pin_q, pin_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pin_d   = pin_q;
    code_we = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_SETUP;
          cnt_d   = '0;
          pin_d   = pin;
          code_we = 1'b1;
        end
      end
      SQ_SETUP: begin
        if (cnt_q == LAST) begin
          state_d = SQ_HOLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_HOLD: begin
        if (cnt_q == LAST) begin
          state_d = SQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      pin_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pin_q   <= pin_d;
    end
  end

  assign busy     = (state_q != SQ_IDLE);
  assign code_val = code;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_stb
    assign stb[p] = (state_q == SQ_HOLD) && (pin_q == PIN_W'(p));
  end

  // R9: a request seen while busy leaves the captured target alone
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(pin_q));

  // R8: at most one pad strobed by the sequencer
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  // R8: busy only ends out of the strobe phase
  assert_end_from_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(state_q == SQ_HOLD));

endmodule

// File: rtl/pull_latched_bank.sv
module pull_latched_bank #(
  parameter int NUM_PINS   = 40,
  localparam int STB_WORDS = (NUM_PINS + 31) / 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_code_we,
  input  logic [STB_WORDS-1:0]  bus_stb_we,
  input  logic [31:0]           wdata,
  input  logic                  seq_code_we,
  input  logic [1:0]            seq_code,
  input  logic [NUM_PINS-1:0]   seq_stb,
  output logic [2*NUM_PINS-1:0] lat_codes
);

  logic [1:0]          code_q;
  logic [NUM_PINS-1:0] stb_q;
  logic [NUM_PINS-1:0] stb_eff;
  logic [1:0]          lat_q [NUM_PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 2'd0;
    end else if (seq_code_we) begin
      code_q <= seq_code;
    end else if (bus_code_we) begin
      code_q <= wdata[1:0];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WORD = p / 32;
    localparam int BIT  = p % 32;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stb_q[p] <= 1'b0;
      end else if (bus_stb_we[WORD]) begin
        stb_q[p] <= wdata[BIT];
      end
    end

    assign stb_eff[p] = stb_q[p] | seq_stb[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q[p] <= 2'd0;
      end else if (stb_eff[p]) begin
        lat_q[p] <= code_q;
      end
    end

    assign lat_codes[2*p +: 2] = lat_q[p];

    // R3: a strobed pad takes the shared code
    assert_take_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb_eff[p] |=> (lat_q[p] == $past(code_q)));

    // R3: an unstrobed pad keeps its code
    assert_hold_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_eff[p] |=> $stable(lat_q[p]));
  end

endmodule

// File: rtl/pull_direct_bank.sv
module pull_direct_bank #(
  parameter int NUM_PINS   = 40,
  localparam int DIR_WORDS = (NUM_PINS + 15) / 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DIR_WORDS-1:0]   we,
  input  logic [31:0]            wdata,
  output logic [2*NUM_PINS-1:0]  fields,
  output logic [32*DIR_WORDS-1:0] rd_words
);

  logic [1:0] fld_q [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WORD = p / 16;
    localparam int SH   = (p % 16) * 2;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q[p] <= 2'd0;
      end else if (we[WORD]) begin
        fld_q[p] <= wdata[SH +: 2];
      end
    end

    assign fields[2*p +: 2]             = fld_q[p];
    assign rd_words[32*WORD + SH +: 2] = fld_q[p];

    // R5: a field changes only when its word is written
    assert_field_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !we[WORD] |=> $stable(fld_q[p]));
  end

  for (genvar u = NUM_PINS; u < 16 * DIR_WORDS; u++) begin : g_unused
    assign rd_words[32*(u/16) + (u%16)*2 +: 2] = 2'd0;
  end

endmodule

// File: rtl/pad_pull_ctrl.sv
module pad_pull_ctrl
  import pad_pull_pkg::*;
#(
  parameter int NUM_PINS    = 40,
  parameter int WAIT_CYCLES = 150,
  localparam int PIN_W      = $clog2(NUM_PINS),
  localparam int STB_WORDS  = (NUM_PINS + 31) / 32,
  localparam int DIR_WORDS  = (NUM_PINS + 15) / 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [7:0]          bus_waddr,
  input  logic [31:0]         bus_wdata,
  input  logic [7:0]          bus_raddr,
  output logic [31:0]         bus_rdata,
  input  logic                dir_mode,
  input  logic                seq_start,
  input  logic [PIN_W-1:0]    seq_pin,
  input  logic [1:0]          seq_code,
  output logic                seq_busy,
  output logic [NUM_PINS-1:0] pad_pull_up,
  output logic [NUM_PINS-1:0] pad_pull_dn
);

  logic                    code_we;
  logic [STB_WORDS-1:0]    stb_we;
  logic [DIR_WORDS-1:0]    dir_we;
  logic                    sq_code_we;
  logic [1:0]              sq_code;
  logic [NUM_PINS-1:0]     sq_stb;
  logic [2*NUM_PINS-1:0]   lat_codes;
  logic [2*NUM_PINS-1:0]   dir_fields;
  logic [32*DIR_WORDS-1:0] dir_rd;

  assign code_we = bus_we && (bus_waddr == ADDR_CODE);

  for (genvar w = 0; w < STB_WORDS; w++) begin : g_stb_dec
    assign stb_we[w] = bus_we && (bus_waddr == ADDR_STB0 + 8'(4 * w));
  end

  for (genvar w = 0; w < DIR_WORDS; w++) begin : g_dir_dec
    assign dir_we[w] = bus_we && (bus_waddr == ADDR_DIR0 + 8'(4 * w));
  end

  always_comb begin
    bus_rdata = 32'd0;
    for (int w = 0; w < DIR_WORDS; w++) begin
      if (bus_raddr == ADDR_DIR0 + 8'(4 * w)) begin
        bus_rdata = dir_rd[32*w +: 32];
      end
    end
  end

  pull_seq #(
    .NUM_PINS    (NUM_PINS),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_start),
    .pin      (seq_pin),
    .code     (seq_code),
    .busy     (seq_busy),
    .code_we  (sq_code_we),
    .code_val (sq_code),
    .stb      (sq_stb)
  );

  pull_latched_bank #(
    .NUM_PINS (NUM_PINS)
  ) u_lat (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_code_we (code_we),
    .bus_stb_we  (stb_we),
    .wdata       (bus_wdata),
    .seq_code_we (sq_code_we),
    .seq_code    (sq_code),
    .seq_stb     (sq_stb),
    .lat_codes   (lat_codes)
  );

  pull_direct_bank #(
    .NUM_PINS (NUM_PINS)
  ) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (dir_we),
    .wdata    (bus_wdata),
    .fields   (dir_fields),
    .rd_words (dir_rd)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    pull_en_t l_en, d_en;
    assign l_en = dec_latched(lat_codes[2*p +: 2]);
    assign d_en = dec_direct(dir_fields[2*p +: 2]);
    assign pad_pull_up[p] = dir_mode ? d_en.up : l_en.up;
    assign pad_pull_dn[p] = dir_mode ? d_en.dn : l_en.dn;
  end

  // R10: never both pulls on one pad
  assert_no_fight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_up & pad_pull_dn) == '0);

  // R7: write-only registers read as zero
  assert_wo_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_raddr == ADDR_CODE) |-> (bus_rdata == 32'd0));

endmodule

// File: tb/pad_pull_ctrl_bench.sv
module pad_pull_ctrl_bench;

  localparam int N    = 40;
  localparam int WAIT = 150;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_waddr;
  logic [31:0] bus_wdata;
  logic [7:0]  bus_raddr;
  logic [31:0] bus_rdata;
  logic        dir_mode;
  logic        seq_start;
  logic [5:0]  seq_pin;
  logic [1:0]  seq_code;
  logic        seq_busy;
  logic [N-1:0] pad_pull_up;
  logic [N-1:0] pad_pull_dn;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pad_pull_ctrl #(.NUM_PINS(N), .WAIT_CYCLES(WAIT)) u_pad_pull_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .dir_mode(dir_mode), .seq_start(seq_start), .seq_pin(seq_pin),
    .seq_code(seq_code), .seq_busy(seq_busy),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
  );

  // {pin[5:0], code[1:0], exp_up, exp_dn}
  localparam logic [9:0] VEC [6] = '{
    {6'd0,  2'd2, 1'b1, 1'b0},
    {6'd5,  2'd1, 1'b0, 1'b1},
    {6'd31, 2'd2, 1'b1, 1'b0},
    {6'd32, 2'd1, 1'b0, 1'b1},
    {6'd39, 2'd3, 1'b0, 1'b0},
    {6'd5,  2'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic strobe_pin(input int p, input logic [1:0] c);
    wr(8'h94, {30'd0, c});
    wr(8'h98 + 8'(4 * (p / 32)), 32'd1 << (p % 32));
    wr(8'h98 + 8'(4 * (p / 32)), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_waddr = '0; bus_wdata = '0; bus_raddr = 8'hE4;
    dir_mode = 1'b0; seq_start = 1'b0; seq_pin = '0; seq_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 up", 64'(pad_pull_up), 64'd0);
    chk("R1 dn", 64'(pad_pull_dn), 64'd0);
    chk("R1 busy", 64'(seq_busy), 64'd0);
    chk("R1 rdata", 64'(bus_rdata), 64'd0);

    // R2/R3 vector walk through the software strobe order
    for (int i = 0; i < 6; i++) begin
      strobe_pin(int'(VEC[i][9:4]), VEC[i][3:2]);
      @(negedge clk);
      chk($sformatf("R2 up pin%0d", VEC[i][9:4]), 64'(pad_pull_up[VEC[i][9:4]]), 64'(VEC[i][1]));
      chk($sformatf("R2 dn pin%0d", VEC[i][9:4]), 64'(pad_pull_dn[VEC[i][9:4]]), 64'(VEC[i][0]));
    end

    // R3 pads not strobed kept their codes: pin0 up, pin31 up, pin32 dn
    chk("R3 hold pin0", 64'(pad_pull_up[0]), 64'd1);
    chk("R3 hold pin31", 64'(pad_pull_up[31]), 64'd1);
    chk("R3 hold pin32", 64'(pad_pull_dn[32]), 64'd1);

    // R4 code change with no strobe
    wr(8'h94, 32'd1);
    @(negedge clk);
    chk("R4 up", 64'(pad_pull_up), 64'h00_8000_0001);
    chk("R4 dn", 64'(pad_pull_dn), 64'h01_0000_0000);

    // R7 write-only registers read zero
    bus_raddr = 8'h94; #1;
    chk("R7 code read", 64'(bus_rdata), 64'd0);
    bus_raddr = 8'h98; #1;
    chk("R7 strobe read", 64'(bus_rdata), 64'd0);

    // R5 direct fields and readback
    wr(8'hE4, 32'h0000_0009);   // pin0 = 1 (up), pin1 = 2 (down)
    wr(8'hE8, 32'hC000_0002);   // pin16 = 2 (down), pin31 = 3 (none)
    wr(8'hEC, 32'hFFFF_FFFF);   // pins 32..39 = 3, nonexistent bits stay 0
    bus_raddr = 8'hE4; #1;
    chk("R5 read word0", 64'(bus_rdata), 64'h0000_0009);
    bus_raddr = 8'hE8; #1;
    chk("R5 read word1", 64'(bus_rdata), 64'hC000_0002);
    bus_raddr = 8'hEC; #1;
    chk("R5 read word2 partial", 64'(bus_rdata), 64'h0000_FFFF);

    // R6 mode select
    @(negedge clk);
    dir_mode = 1'b1;
    #1;
    chk("R6 R5 direct up", 64'(pad_pull_up), 64'h00_0000_0001);
    chk("R6 R5 direct dn", 64'(pad_pull_dn), 64'h00_0001_0002);
    dir_mode = 1'b0;
    #1;
    chk("R6 latched up", 64'(pad_pull_up), 64'h00_8000_0001);

    // R8/R9 sequencer with an ignored request during the run
    @(negedge clk);
    seq_start = 1'b1; seq_pin = 6'd20; seq_code = 2'd2;
    @(negedge clk);
    seq_start = 1'b0;
    begin
      int cnt = 0;
      while (seq_busy && cnt < 2 * WAIT + 20) begin
        cnt++;
        if (cnt == 10) begin
          seq_start = 1'b1; seq_pin = 6'd7; seq_code = 2'd1;
        end else begin
          seq_start = 1'b0;
        end
        if (cnt == 50) begin
          chk("R8 pad unchanged in setup", 64'(pad_pull_up[20]), 64'd0);
        end
        @(negedge clk);
      end
      seq_start = 1'b0;
      chk("R8 R9 busy length", 64'(cnt), 64'(2 * WAIT));
    end
    chk("R8 target up", 64'(pad_pull_up[20]), 64'd1);
    chk("R8 target dn", 64'(pad_pull_dn[20]), 64'd0);
    chk("R9 ignored pad dn", 64'(pad_pull_dn[7]), 64'd0);
    chk("R8 others up", 64'(pad_pull_up), 64'h00_8010_0001);

    // R8 second request after idle, pull-down on a high-word pad
    @(negedge clk);
    seq_start = 1'b1; seq_pin = 6'd38; seq_code = 2'd1;
    @(negedge clk);
    seq_start = 1'b0;
    repeat (2 * WAIT + 2) @(negedge clk);
    chk("R8 second busy", 64'(seq_busy), 64'd0);
    chk("R8 second dn", 64'(pad_pull_dn[38]), 64'd1);
    chk("R10 no fight", 64'(pad_pull_up & pad_pull_dn), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule